// File: doc/BRIEF.md
# NAND Page Read Sequencer

This block drives a raw 8-bit NAND flash device to read one page. A start pulse chooses one of three operations: fetch the five identification bytes, fetch the spare area of a page, or fetch the main data of a page. The page is named by a block number and a page index inside that block. Configuration inputs give the page geometry: 512 or 2048 bytes per page, two or three row-address bytes, and the number of pages per block.

The sequencer first issues command and address bytes on the shared byte bus. Each byte is framed by its latch strobe and clocked in with a write-enable pulse. Page reads then wait on the ready/busy pin. After that, each byte comes from one read-enable pulse and is handed downstream over a valid/ready stream. Small pages and large pages differ in the address phase. A small page uses a single column byte and has its own spare-area command. A large page uses two column bytes and a confirm command, and its spare area is reached by a column equal to the page size.

Top module: `nand_page_reader`

## Requirements
- R1: The row address is `blk * ppb + pg`. It is sent least-significant byte first, as two bytes, or as three bytes when `cfg_row3` is 1, with the third byte carrying row bits 23:16.
- R2: With `op` = 2'b10 or 2'b11 (main read), the bytes sent are command 0x00 and then a zero column. The column is one byte 0x00 when `cfg_large` is 0, or two bytes 0x00 0x00 when `cfg_large` is 1. The row bytes follow. Only when `cfg_large` is 1 does a final command 0x30 come after them.
- R3: With `op` = 2'b01 (spare read), small pages send command 0x50, column byte 0x00, then the row. Large pages send command 0x00, column bytes 0x00 then 0x08 (column 2048), the row, then command 0x30.
- R4: With `op` = 2'b00 (ID read), the bytes sent are command 0x90 and address 0x00. No ready wait follows, and exactly 5 data bytes are delivered.
- R5: A main read delivers exactly the page size in bytes (512 or 2048). A spare read delivers exactly the page size divided by 32 (16 or 64). Each byte costs exactly one read-enable pulse.
- R6: After the address phase of a page read, the block waits for `nf_rb` to go low, giving up after POLL_LIMIT cycles. It then waits with no bound for `nf_rb` to be high. No read-enable pulse is issued before that point.
- R7: Each command byte is framed by `nf_cle` and each address byte by `nf_ale`. Exactly one of the two is high while `nf_we_n` is low. The strobe and byte are set up for SETUP_CYC cycles, and `nf_we_n` is then low for exactly WE_CYC cycles with `nf_dout` stable.
- R8: Each data byte is captured from `nf_dq` as `nf_re_n` rises after RE_CYC low cycles. It is offered on `m_data` with `m_valid`, and both are held unchanged until `m_ready` accepts it.
- R9: `busy` rises the cycle after an accepted `start` and stays high until the last byte is accepted. `done` pulses for one cycle as `busy` falls. While idle all strobes are inactive. A `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (honoured only when idle) |
| op | input | 2 | 00 ID read, 01 spare read, 1x main read |
| blk | input | BLK_W | Block number |
| pg | input | PG_W | Page index inside the block |
| ppb | input | PG_W+1 | Pages per block |
| cfg_large | input | 1 | 1: 2048-byte pages, 0: 512-byte pages |
| cfg_row3 | input | 1 | 1: three row-address bytes, 0: two |
| nf_cle | output | 1 | Command latch strobe |
| nf_ale | output | 1 | Address latch strobe |
| nf_we_n | output | 1 | Write-enable, active low |
| nf_re_n | output | 1 | Read-enable, active low |
| nf_dout | output | 8 | Command/address byte to the device |
| nf_oe | output | 1 | Drive enable for `nf_dout` onto the shared bus |
| nf_dq | input | 8 | Data byte from the device |
| nf_rb | input | 1 | Ready (1) / busy (0) from the device |
| m_valid | output | 1 | Stream byte valid |
| m_data | output | 8 | Stream byte |
| m_ready | input | 1 | Stream consumer ready |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |

## Verification
The hardest case to reach is the ready wait ending by timeout, where the device never shows busy. The bench's device model holds `nf_rb` high through a whole main read and measures the gap from the last write-enable rise to the first read-enable fall against the poll limit. In the usual case the model pulls `nf_rb` low after a random delay for a random time and counts read strobes during that window. Random backpressure on `m_ready`, a stray `start` issued mid-operation, and an `op` value of 3 round out the stimulus.

// File: rtl/nand_page_reader.sv
module nand_page_reader #(
  parameter int BLK_W      = 12,
  parameter int PG_W       = 8,
  parameter int SETUP_CYC  = 2,
  parameter int WE_CYC     = 2,
  parameter int RE_CYC     = 2,
  parameter int POLL_LIMIT = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       op,
  input  logic [BLK_W-1:0] blk,
  input  logic [PG_W-1:0]  pg,
  input  logic [PG_W:0]    ppb,
  input  logic             cfg_large,
  input  logic             cfg_row3,
  output logic             nf_cle,
  output logic             nf_ale,
  output logic             nf_we_n,
  output logic             nf_re_n,
  output logic [7:0]       nf_dout,
  output logic             nf_oe,
  input  logic [7:0]       nf_dq,
  input  logic             nf_rb,
  output logic             m_valid,
  output logic [7:0]       m_data,
  input  logic             m_ready,
  output logic             busy,
  output logic             done
);
  localparam int TMR_W  = $clog2(SETUP_CYC + WE_CYC + RE_CYC + 1);
  localparam int POLL_W = $clog2(POLL_LIMIT + 1);
  localparam int LEN_W  = 12;

  typedef enum logic [2:0] {IDLE, C_SETUP, C_PULSE, C_HOLD, W_LOW, W_HIGH, R_PULSE, R_OUT} st_t;

  st_t              st;
  logic [1:0]       op_q;
  logic             large_q, row3_q;
  logic [23:0]      row_q;
  logic [2:0]       step;
  logic [TMR_W-1:0] tmr;
  logic [POLL_W-1:0] poll;
  logic [LEN_W-1:0] remain;
  logic [LEN_W-1:0] len_m1;
  logic             cur_cmd;
  logic [7:0]       cur_byte;
  logic [2:0]       ncol, nrow, last;

  wire is_id    = (op_q == 2'b00);
  wire is_spare = (op_q == 2'b01);
  wire in_cmd   = (st == C_SETUP) || (st == C_PULSE) || (st == C_HOLD);

  assign ncol = (!is_id && large_q) ? 3'd2 : 3'd1;
  assign nrow = is_id ? 3'd0 : (row3_q ? 3'd3 : 3'd2);
  assign last = ncol + nrow + {2'b00, (!is_id && large_q)};

  always_comb begin
    cur_cmd  = 1'b0;
    cur_byte = 8'h00;
    if (step == 3'd0) begin
      cur_cmd  = 1'b1;
      cur_byte = is_id ? 8'h90 : ((is_spare && !large_q) ? 8'h50 : 8'h00);
    end else if (step <= ncol) begin
      cur_byte = (step == 3'd2 && is_spare) ? 8'h08 : 8'h00;
    end else if (step <= ncol + nrow) begin
      case (step - ncol)
        3'd1:    cur_byte = row_q[7:0];
        3'd2:    cur_byte = row_q[15:8];
        default: cur_byte = row_q[23:16];
      endcase
    end else begin
      cur_cmd  = 1'b1;
      cur_byte = 8'h30;
    end
  end

  always_comb begin
    case (op)
      2'b00:   len_m1 = LEN_W'(4);
      2'b01:   len_m1 = cfg_large ? LEN_W'(63) : LEN_W'(15);
      default: len_m1 = cfg_large ? LEN_W'(2047) : LEN_W'(511);
    endcase
  end

  assign nf_cle  = in_cmd && cur_cmd;
  assign nf_ale  = in_cmd && !cur_cmd;
  assign nf_we_n = (st != C_PULSE);
  assign nf_re_n = (st != R_PULSE);
  assign nf_dout = cur_byte;
  assign nf_oe   = in_cmd;
  assign busy    = (st != IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      op_q    <= 2'b00;
      large_q <= 1'b0;
      row3_q  <= 1'b0;
      row_q   <= '0;
      step    <= '0;
      tmr     <= '0;
      poll    <= '0;
      remain  <= '0;
      m_valid <= 1'b0;
      m_data  <= 8'h00;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          op_q    <= op;
          large_q <= cfg_large;
          row3_q  <= cfg_row3;
          row_q   <= 24'(blk) * 24'(ppb) + 24'(pg);
          remain  <= len_m1;
          step    <= '0;
          tmr     <= '0;
          st      <= C_SETUP;
        end
        C_SETUP: if (tmr == TMR_W'(SETUP_CYC - 1)) begin
          tmr <= '0;
          st  <= C_PULSE;
        end else tmr <= tmr + 1'b1;
        C_PULSE: if (tmr == TMR_W'(WE_CYC - 1)) begin
          tmr <= '0;
          st  <= C_HOLD;
        end else tmr <= tmr + 1'b1;
        C_HOLD: if (step == last) begin
          poll <= '0;
          st   <= is_id ? R_PULSE : W_LOW;
        end else begin
          step <= step + 1'b1;
          st   <= C_SETUP;
        end
        W_LOW: if (!nf_rb || poll == POLL_W'(POLL_LIMIT - 1)) st <= W_HIGH;
               else poll <= poll + 1'b1;
        W_HIGH: if (nf_rb) begin
          tmr <= '0;
          st  <= R_PULSE;
        end
        R_PULSE: if (tmr == TMR_W'(RE_CYC - 1)) begin
          tmr     <= '0;
          m_data  <= nf_dq;
          m_valid <= 1'b1;
          st      <= R_OUT;
        end else tmr <= tmr + 1'b1;
        R_OUT: if (m_ready) begin
          m_valid <= 1'b0;
          if (remain == '0) begin
            done <= 1'b1;
            st   <= IDLE;
          end else begin
            remain <= remain - 1'b1;
            st     <= R_PULSE;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module nand_page_reader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       nf_cle,
  input logic       nf_ale,
  input logic       nf_we_n,
  input logic       nf_re_n,
  input logic       nf_rb,
  input logic [7:0] nf_dout,
  input logic       m_valid,
  input logic       m_ready,
  input logic [7:0] m_data
);
  assert_one_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !nf_we_n |-> (nf_cle ^ nf_ale));
  assert_dout_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!nf_we_n && !$past(nf_we_n)) |-> $stable(nf_dout));
  assert_stream_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));
  assert_read_when_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !nf_re_n |-> nf_rb);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_quiet_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (nf_we_n && nf_re_n && !nf_cle && !nf_ale && !m_valid));
  assert_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
endmodule

bind nand_page_reader nand_page_reader_chk u_chk (.*);

// File: tb/tb_nand_page_reader.sv
module tb_nand_page_reader;
  localparam int SETUP = 2, WEC = 2, REC = 2, POLL = 1000;

  logic clk = 1'b0;
  logic rst_n;
  logic start = 1'b0;
  logic [1:0] op = 2'b00;
  logic [11:0] blk = '0;
  logic [7:0] pg = '0;
  logic [8:0] ppb = 9'd64;
  logic cfg_large = 1'b0, cfg_row3 = 1'b0;
  logic nf_cle, nf_ale, nf_we_n, nf_re_n, nf_oe;
  logic [7:0] nf_dout;
  logic [7:0] nf_dq = 8'h00;
  logic nf_rb = 1'b1;
  logic m_valid, m_ready = 1'b0, busy, done;
  logic [7:0] m_data;

  always #10 clk = ~clk;

  nand_page_reader #(.BLK_W(12), .PG_W(8), .SETUP_CYC(SETUP), .WE_CYC(WEC),
                     .RE_CYC(REC), .POLL_LIMIT(POLL)) dut (.*);

  int checks = 0, errors = 0;
  longint cyc = 0;
  int re_falls = 0, re_base = 0, cap_tot = 0;
  int cur_row = 0;
  logic [7:0] cap_b [0:63];
  logic       cap_c [0:63];
  logic [7:0] exp_b [0:15];
  logic       exp_c [0:15];
  int exp_n;
  int we_lo = 0, re_lo = 0, bad_w = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] pat(input int row, input int i);
    return 8'(row ^ (i * 7) ^ (i >> 4));
  endfunction

  always @(negedge nf_re_n) if (rst_n === 1'b1) begin
    nf_dq    <= pat(cur_row, re_falls - re_base);
    re_falls <= re_falls + 1;
  end

  always @(posedge nf_we_n) if (rst_n === 1'b1 && (nf_cle === 1'b1 || nf_ale === 1'b1)) begin
    cap_b[cap_tot % 64] = nf_dout;
    cap_c[cap_tot % 64] = nf_cle;
    cap_tot = cap_tot + 1;
  end

  always @(negedge clk) if (rst_n === 1'b1) begin
    if (!nf_we_n) we_lo++;
    else if (we_lo != 0) begin if (we_lo != WEC) bad_w++; we_lo = 0; end
    if (!nf_re_n) re_lo++;
    else if (re_lo != 0) begin if (re_lo != REC) bad_w++; re_lo = 0; end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic add_exp(input logic [7:0] b, input logic c);
    exp_b[exp_n] = b; exp_c[exp_n] = c; exp_n++;
  endtask

  task automatic build_exp(input int o, input bit lg, input bit r3, input int row);
    exp_n = 0;
    if (o == 0) begin
      add_exp(8'h90, 1'b1); add_exp(8'h00, 1'b0);
    end else begin
      add_exp((o == 1 && !lg) ? 8'h50 : 8'h00, 1'b1);
      add_exp(8'h00, 1'b0);
      if (lg) add_exp((o == 1) ? 8'h08 : 8'h00, 1'b0);
      add_exp(8'(row), 1'b0);
      add_exp(8'(row >> 8), 1'b0);
      if (r3) add_exp(8'(row >> 16), 1'b0);
      if (lg) add_exp(8'h30, 1'b1);
    end
  endtask

  task automatic run_op(input int o, input bit lg, input bit r3, input int b, input int p,
                        input int pp, input bit no_busy, input int d, input int l, input bit intrude);
    int row, len, cb, bw0, rowlo, rowhi, bad_seq, bad_row;
    string tag;
    row = b * pp + p;
    len = (o == 0) ? 5 : (o == 1) ? (lg ? 64 : 16) : (lg ? 2048 : 512);
    tag = (o == 0) ? "R4" : (o == 1) ? "R3" : "R2";
    build_exp(o, lg, r3, row);
    cur_row = row;
    cb = cap_tot; re_base = re_falls; bw0 = bad_w;
    @(negedge clk);
    op = 2'(o); cfg_large = lg; cfg_row3 = r3; blk = 12'(b); pg = 8'(p); ppb = 9'(pp);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R9", "busy after start", longint'(busy), 1);
    fork
      begin
        int rf;
        longint t0;
        while (cap_tot - cb < exp_n) @(negedge clk);
        if (intrude) begin
          op = 2'b00; start = 1'b1; @(negedge clk); start = 1'b0;
        end
        if (o != 0) begin
          if (!no_busy) begin
            repeat (d) @(negedge clk);
            nf_rb = 1'b0; rf = re_falls;
            repeat (l) @(negedge clk);
            chk(re_falls == rf, "R6", "read strobes while busy", re_falls - rf, 0);
            nf_rb = 1'b1;
          end else begin
            t0 = cyc;
            while (re_falls == re_base) @(negedge clk);
            chk((cyc - t0 >= POLL) && (cyc - t0 <= POLL + 8), "R6", "timeout gap cycles", cyc - t0, POLL);
          end
        end
      end
      begin
        int got, bad, first_a, first_e;
        bit rdy;
        got = 0; bad = 0; first_a = 0; first_e = 0;
        while (got < len) begin
          @(negedge clk);
          rdy = ($urandom % 4) != 0;
          m_ready = rdy;
          if (m_valid && rdy) begin
            if (m_data !== pat(row, got)) begin
              if (bad == 0) begin first_a = int'(m_data); first_e = int'(pat(row, got)); end
              bad++;
            end
            got++;
          end
        end
        @(negedge clk);
        m_ready = 1'b0;
        chk(done === 1'b1 && busy === 1'b0, "R9", "done pulse at end", longint'({done, busy}), 2);
        @(negedge clk);
        chk(done === 1'b0, "R9", "done lasts one cycle", longint'(done), 0);
        chk(bad == 0, "R8", "stream byte", first_a, first_e);
      end
    join
    chk(re_falls - re_base == len, "R5", "read strobes per op", re_falls - re_base, len);
    chk(cap_tot - cb == exp_n, tag, "cmd/addr byte count", cap_tot - cb, exp_n);
    bad_seq = 0; bad_row = 0;
    rowlo = (o == 0) ? 99 : (lg ? 3 : 2);
    rowhi = rowlo + (r3 ? 3 : 2);
    for (int k = 0; k < exp_n; k++) begin
      if (cap_b[(cb + k) % 64] !== exp_b[k] || cap_c[(cb + k) % 64] !== exp_c[k]) begin
        if (k >= rowlo && k < rowhi) bad_row++; else bad_seq++;
      end
    end
    chk(bad_seq == 0, tag, "command/column bytes wrong", bad_seq, 0);
    if (o != 0) chk(bad_row == 0, "R1", "row bytes wrong", bad_row, 0);
    chk(bad_w == bw0, "R7", "strobe widths wrong", bad_w - bw0, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234abcd));
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && m_valid === 1'b0 && nf_we_n === 1'b1 &&
        nf_re_n === 1'b1 && nf_cle === 1'b0 && nf_ale === 1'b0, "R9", "reset state",
        longint'({busy, done, m_valid, nf_cle, nf_ale}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_op(2, 0, 0, 3, 5, 32, 0, 3, 7, 0);
    run_op(2, 1, 1, 1000, 127, 128, 0, 0, 12, 0);
    run_op(1, 0, 0, 7, 2, 64, 0, 5, 3, 0);
    run_op(1, 1, 1, 4000, 200, 256, 0, 2, 20, 0);
    run_op(0, 0, 0, 0, 0, 64, 0, 0, 0, 0);
    run_op(2, 0, 0, 9, 1, 32, 1, 0, 0, 0);
    run_op(1, 1, 0, 12, 3, 64, 0, 4, 9, 1);
    run_op(3, 0, 1, 255, 31, 32, 0, 1, 5, 0);
    for (int n = 0; n < 6; n++) begin
      int o;
      o = int'($urandom % 3);
      if (o == 2 && ($urandom % 2) == 0) o = 1;
      run_op(o, 1'($urandom % 2), 1'($urandom % 2), int'($urandom % 4096), int'($urandom % 128),
             128, 0, int'($urandom % 20), 1 + int'($urandom % 40), 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule